// File: doc/BRIEF.md
# Stream Put Execution Unit

This unit carries out the processor instruction that pushes one word from a general register onto one of several outgoing stream links. It decodes the instruction word and picks the target link, falling back to link 0 when the index names a link that does not exist. It drives a shared data bus, a control-flag line and one write strobe per link. The instruction flags decide the rest: whether the pipeline stalls or a carry flag reports the outcome, whether the word is tagged as control, whether the write is only probed, and whether interrupts are held off. When the privilege check is built in, a put attempted in user mode is turned into a privileged-instruction exception request.

The pipeline holds `issue_valid` and the instruction word steady for as long as `stall` is high. The register file reads the register named by `src_idx` and returns its value on `src_val` in the same cycle. All outputs except `carry` follow the inputs within the cycle. `carry` is a register that changes at the clock edge that completes a non-blocking put.

Top module: `strm_put_unit`

## Requirements
- R1: A put is recognised only when `issue_valid`=1, `instr[31:26]`=6'b011011, `instr[25:21]`=0, `instr[15]`=1 and `instr[10:4]`=0. In any other cycle `stall`, `link_wr`, `link_ctrl`, `priv_exc` and `irq_inhibit` are 0 and `carry` keeps its value.
- R2: The link index is `instr[3:0]`. An index greater than or equal to NUM_LINKS selects link 0. At most one bit of `link_wr` is high, and it is the bit of the selected link.
- R3: `link_wdata` equals `src_val` and `src_idx` equals `instr[20:16]`. During a recognised put, `link_ctrl` equals the control bit `instr[13]`.
- R4: Blocking put (`instr[14]`=0): while the selected link's `link_full` bit is 1, `stall`=1 and no strobe is raised. In the first cycle the bit is 0, `stall`=0 and the write completes.
- R5: Non-blocking put (`instr[14]`=1): `stall` stays 0. At the clock edge `carry` becomes the selected link's full bit. A strobe is raised only when that bit is 0.
- R6: Test-only put (`instr[12]`=1): stall and carry behave as in R4 and R5, and `link_wr` stays 0.
- R7: Atomic put (`instr[11]`=1): `irq_inhibit`=1 in every cycle the instruction is presented, stall cycles included.
- R8: With MMU_EN=1 and PRIV_ALLOW=0, a recognised put with `user_mode`=1 gives `priv_exc`=1, `stall`=0, `link_wr`=0 and `irq_inhibit`=0, and leaves `carry` unchanged. With `user_mode`=0 the put runs normally.
- R9: After reset `carry` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| issue_valid | input | 1 | Instruction word is presented this cycle |
| instr | input | 32 | Instruction word |
| user_mode | input | 1 | Processor runs in user mode |
| src_val | input | DATA_W | Value of the source register |
| link_full | input | NUM_LINKS | Per-link full flag |
| src_idx | output | 5 | Source register index for the register file |
| link_wdata | output | DATA_W | Data broadcast to all links |
| link_ctrl | output | 1 | Control tag sent with the data |
| link_wr | output | NUM_LINKS | Per-link write strobe |
| stall | output | 1 | Pipeline stall request |
| carry | output | 1 | Carry flag set by non-blocking puts |
| priv_exc | output | 1 | Privileged-instruction exception request |
| irq_inhibit | output | 1 | Hold off interrupts for this instruction |

## Verification
The bench builds the unit with NUM_LINKS=4, DATA_W=32, MMU_EN=1 and PRIV_ALLOW=0. With four links, the indices 4 and 15 fall outside the range and exercise the fallback to link 0. The privilege trap is built in, so the user-mode path is reachable. All sixteen flag combinations run against both a free and a full target link. The other links carry the opposite full state, so a wrong link choice shows up in stall, carry and strobe.

// File: rtl/strm_put_pkg.sv
`timescale 1ns/1ps
package strm_put_pkg;
   localparam int          IW_W      = 32;
   localparam int          LINK_IW   = 4;
   localparam int          REG_IW    = 5;
   localparam logic [5:0]  PUT_MAJOR = 6'b011011;

   typedef struct packed {
      logic               is_put;
      logic               nb;
      logic               ctrl;
      logic               test;
      logic               atom;
      logic [REG_IW-1:0]  src;
      logic [LINK_IW-1:0] link;
   } put_op_t;

   function automatic put_op_t decode_put(input logic vld, input logic [IW_W-1:0] iw);
      put_op_t o;
      o.is_put = vld && (iw[31:26] == PUT_MAJOR) && (iw[25:21] == 5'd0)
                 && iw[15] && (iw[10:4] == 7'd0);
      o.nb     = iw[14];
      o.ctrl   = iw[13];
      o.test   = iw[12];
      o.atom   = iw[11];
      o.src    = iw[20:16];
      o.link   = iw[3:0];
      return o;
   endfunction
endpackage

// File: rtl/strm_put_decode.sv
`timescale 1ns/1ps
module strm_put_decode
   import strm_put_pkg::*;
(
   input  logic            issue_valid,
   input  logic [IW_W-1:0] instr,
   output put_op_t         op
);
   always_comb op = decode_put(issue_valid, instr);
endmodule

// File: rtl/strm_put_route.sv
`timescale 1ns/1ps
module strm_put_route
   import strm_put_pkg::*;
#(
   parameter int NUM_LINKS = 8
)(
   input  logic [LINK_IW-1:0]   link_idx,
   input  logic [NUM_LINKS-1:0] link_full,
   output logic [NUM_LINKS-1:0] sel_oh,
   output logic                 space
);
   logic [NUM_LINKS-1:0] hit;

   for (genvar i = 0; i < NUM_LINKS; i++) begin : g_hit
      assign hit[i] = (link_idx == LINK_IW'(i));
   end

   always_comb begin
      sel_oh = hit;
      if (hit == '0) sel_oh[0] = 1'b1;
   end

   assign space = ~|(sel_oh & link_full);
endmodule

// File: rtl/strm_put_ctrl.sv
`timescale 1ns/1ps
module strm_put_ctrl
   import strm_put_pkg::*;
#(
   parameter bit MMU_EN     = 1'b1,
   parameter bit PRIV_ALLOW = 1'b0
)(
   input  logic    clk,
   input  logic    rst_n,
   input  put_op_t op,
   input  logic    space,
   input  logic    user_mode,
   output logic    stall,
   output logic    wr_go,
   output logic    priv_exc,
   output logic    irq_inhibit,
   output logic    carry
);
   localparam bit TRAP_EN = MMU_EN && !PRIV_ALLOW;

   logic trap;
   logic act;

   if (TRAP_EN) begin : g_trap
      assign trap = op.is_put & user_mode;
   end else begin : g_notrap
      logic unused_um;
      assign unused_um = user_mode;
      assign trap = 1'b0;
   end

   assign act         = op.is_put & ~trap;
   assign stall       = act & ~op.nb & ~space;
   assign wr_go       = act & space & ~op.test;
   assign irq_inhibit = act & op.atom;
   assign priv_exc    = trap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               carry <= 1'b0;
      else if (act && op.nb)    carry <= ~space;
   end

   assert_nb_nostall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (op.is_put && op.nb) |-> !stall);
   assert_stall_nowr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> !wr_go);
   assert_test_nowr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (op.is_put && op.test) |-> !wr_go);
   assert_trap_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      priv_exc |-> (!stall && !wr_go && !irq_inhibit));
   assert_trap_carry_R8: assert property (@(posedge clk) disable iff (!rst_n)
      priv_exc |=> $stable(carry));
   assert_idle_carry_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !op.is_put |=> $stable(carry));
endmodule

// File: rtl/strm_put_unit.sv
`timescale 1ns/1ps
module strm_put_unit
   import strm_put_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int NUM_LINKS  = 8,
   parameter bit MMU_EN     = 1'b1,
   parameter bit PRIV_ALLOW = 1'b0
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 issue_valid,
   input  logic [31:0]          instr,
   input  logic                 user_mode,
   input  logic [DATA_W-1:0]    src_val,
   input  logic [NUM_LINKS-1:0] link_full,
   output logic [4:0]           src_idx,
   output logic [DATA_W-1:0]    link_wdata,
   output logic                 link_ctrl,
   output logic [NUM_LINKS-1:0] link_wr,
   output logic                 stall,
   output logic                 carry,
   output logic                 priv_exc,
   output logic                 irq_inhibit
);
   if (NUM_LINKS < 1 || NUM_LINKS > (1 << LINK_IW)) begin : g_bad_links
      $error("NUM_LINKS must lie between 1 and 16");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be positive");
   end

   put_op_t              op;
   logic [NUM_LINKS-1:0] sel_oh;
   logic                 space;
   logic                 wr_go;

   strm_put_decode u_dec (
      .issue_valid (issue_valid),
      .instr       (instr),
      .op          (op)
   );

   strm_put_route #(.NUM_LINKS(NUM_LINKS)) u_route (
      .link_idx  (op.link),
      .link_full (link_full),
      .sel_oh    (sel_oh),
      .space     (space)
   );

   strm_put_ctrl #(.MMU_EN(MMU_EN), .PRIV_ALLOW(PRIV_ALLOW)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .op          (op),
      .space       (space),
      .user_mode   (user_mode),
      .stall       (stall),
      .wr_go       (wr_go),
      .priv_exc    (priv_exc),
      .irq_inhibit (irq_inhibit),
      .carry       (carry)
   );

   assign src_idx    = op.src;
   assign link_wdata = src_val;
   assign link_ctrl  = op.is_put & op.ctrl;
   assign link_wr    = sel_oh & {NUM_LINKS{wr_go}};

   assert_wr_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(link_wr));
   assert_wr_notfull_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (link_wr & link_full) == '0);
   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !issue_valid |-> (link_wr == '0 && !stall && !priv_exc && !irq_inhibit));
endmodule

// File: tb/sim_strm_put_unit.sv
`timescale 1ns/1ps
module sim_strm_put_unit;
   localparam int NL = 4;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          issue_valid = 1'b0;
   logic [31:0]   instr = '0;
   logic          user_mode = 1'b0;
   logic [DW-1:0] src_val = '0;
   logic [NL-1:0] link_full = '0;
   logic [4:0]    src_idx;
   logic [DW-1:0] link_wdata;
   logic          link_ctrl;
   logic [NL-1:0] link_wr;
   logic          stall, carry, priv_exc, irq_inhibit;

   int  checks = 0;
   int  errors = 0;
   bit  mc = 1'b0;
   bit  finished = 1'b0;

   always #2 clk = ~clk;

   strm_put_unit #(.DATA_W(DW), .NUM_LINKS(NL), .MMU_EN(1'b1), .PRIV_ALLOW(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .instr(instr),
      .user_mode(user_mode), .src_val(src_val), .link_full(link_full),
      .src_idx(src_idx), .link_wdata(link_wdata), .link_ctrl(link_ctrl),
      .link_wr(link_wr), .stall(stall), .carry(carry), .priv_exc(priv_exc),
      .irq_inhibit(irq_inhibit)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input bit n, input bit c, input bit t, input bit a,
                                      input logic [3:0] lk, input logic [4:0] rs);
      return {6'b011011, 5'b00000, rs, 1'b1, n, c, t, a, 7'b0000000, lk};
   endfunction

   task automatic cyc(input bit v, input logic [31:0] iw, input bit um,
                      input logic [NL-1:0] fv, input logic [DW-1:0] d);
      bit   put, trap, act, spc;
      int   sel;
      logic [NL-1:0] e_wr;
      @(negedge clk);
      issue_valid = v; instr = iw; user_mode = um; link_full = fv; src_val = d;
      #1;
      put  = v && iw[31:26] == 6'b011011 && iw[25:21] == 5'd0 && iw[15] && iw[10:4] == 7'd0;
      trap = put && um;
      act  = put && !um;
      sel  = (int'(iw[3:0]) < NL) ? int'(iw[3:0]) : 0;
      spc  = !fv[sel];
      e_wr = (act && spc && !iw[12]) ? NL'(1 << sel) : '0;
      chk(link_wr == e_wr, "R2 R4 R5 R6 strobe", 64'(link_wr), 64'(e_wr));
      chk(stall == (act && !iw[14] && !spc), "R4 R5 stall", 64'(stall), 64'(act && !iw[14] && !spc));
      chk(carry == mc, "R5 R8 carry", 64'(carry), 64'(mc));
      chk(link_ctrl == (put && iw[13]), "R3 ctrl", 64'(link_ctrl), 64'(put && iw[13]));
      chk(link_wdata == d, "R3 data", 64'(link_wdata), 64'(d));
      chk(src_idx == iw[20:16], "R3 srcidx", 64'(src_idx), 64'(iw[20:16]));
      chk(irq_inhibit == (act && iw[11]), "R7 irq", 64'(irq_inhibit), 64'(act && iw[11]));
      chk(priv_exc == trap, "R8 priv", 64'(priv_exc), 64'(trap));
      if (!put) chk(link_wr == '0 && !stall, "R1 idle", 64'({link_wr, stall}), 64'd0);
      if (act && iw[14]) mc = !spc;
   endtask

   function automatic logic [NL-1:0] fpat(input logic [3:0] lk, input bit full);
      int s = (int'(lk) < NL) ? int'(lk) : 0;
      logic [NL-1:0] oh = NL'(1 << s);
      return full ? oh : ~oh;
   endfunction

   initial begin
      int idxs[6] = '{0, 1, 2, 3, 4, 15};
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(carry == 1'b0, "R9 reset carry", 64'(carry), 64'd0);
      chk(link_wr == '0 && !stall, "R1 reset idle", 64'({link_wr, stall}), 64'd0);
      // R1: not a put
      cyc(1'b0, mk(1'b0, 1'b0, 1'b0, 1'b0, 4'd1, 5'd3), 1'b0, 4'b0000, 32'h11);
      cyc(1'b1, mk(1'b0, 1'b0, 1'b0, 1'b0, 4'd1, 5'd3) ^ 32'h0400_0000, 1'b0, 4'b0000, 32'h12);
      cyc(1'b1, mk(1'b1, 1'b0, 1'b0, 1'b0, 4'd1, 5'd3) & ~32'h0000_8000, 1'b0, 4'b1111, 32'h13);
      cyc(1'b1, mk(1'b0, 1'b0, 1'b0, 1'b0, 4'd1, 5'd3) | 32'h0000_0040, 1'b0, 4'b0000, 32'h14);
      cyc(1'b1, mk(1'b0, 1'b0, 1'b0, 1'b0, 4'd1, 5'd3) | 32'h0020_0000, 1'b0, 4'b0000, 32'h15);
      // All 16 variants, free and full target, in-range and fallback indices
      for (int f = 0; f < 16; f++) begin
         for (int fl = 0; fl < 2; fl++) begin
            foreach (idxs[k]) begin
               logic [3:0] lk = 4'(idxs[k]);
               cyc(1'b1, mk(f[3], f[2], f[1], f[0], lk, 5'(f + k)), 1'b0,
                   fpat(lk, fl[0]), 32'hA000_0000 + 32'(f * 16 + fl * 8 + k));
            end
         end
      end
      // R4: blocking put held by a full link, then released
      for (int s = 0; s < 4; s++)
         cyc(1'b1, mk(1'b0, 1'b1, 1'b0, 1'b1, 4'd2, 5'd9), 1'b0, 4'b0100, 32'hBEEF);
      cyc(1'b1, mk(1'b0, 1'b1, 1'b0, 1'b1, 4'd2, 5'd9), 1'b0, 4'b1011, 32'hBEEF);
      // R8: trap keeps carry; set carry to 1 first, then trap with a free link
      cyc(1'b1, mk(1'b1, 1'b0, 1'b0, 1'b0, 4'd3, 5'd1), 1'b0, 4'b1000, 32'h1);
      cyc(1'b1, mk(1'b1, 1'b0, 1'b0, 1'b1, 4'd3, 5'd1), 1'b1, 4'b0000, 32'h2);
      cyc(1'b1, mk(1'b0, 1'b1, 1'b0, 1'b1, 4'd0, 5'd1), 1'b1, 4'b1111, 32'h3);
      cyc(1'b1, mk(1'b1, 1'b0, 1'b0, 1'b0, 4'd9, 5'd1), 1'b1, 4'b0000, 32'h4);
      cyc(1'b0, 32'h0, 1'b0, 4'b0000, 32'h5);
      cyc(1'b1, mk(1'b1, 1'b0, 1'b0, 1'b0, 4'd9, 5'd1), 1'b0, 4'b0000, 32'h6);
      cyc(1'b0, 32'h0, 1'b0, 4'b1111, 32'h7);
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule